// File: doc/BRIEF.md
# Variable-Slot Retire Queue

This block is the in-order retirement stage of an out-of-order core model. It is a circular buffer of slots. Each instruction entering the machine reserves a contiguous run of slots sized by its micro-op count. The block hands back a token, which is the index of the first slot of that run. Execution units later report completion by presenting that token. The block then retires completed instructions strictly in program order from the head and gives their slots back.

A requested micro-op count is normalized before use. Zero becomes one, and anything above the queue depth becomes the depth. Because of this, the head and tail pointers step by a per-entry amount rather than by one. Each cycle, up to a configured number of consecutive completed entries leave the queue. Each one is reported on its own retire lane, and the free-slot count takes account of reservations and retirements in the same cycle.

Top module: `retire_queue`

## Requirements
- R1: After reset the queue is empty: the free-slot count equals DEPTH, the offered token is 0, no retire lane is valid and a request is accepted.
- R2: A request of N micro-ops occupies max(1, min(N, DEPTH)) slots. The occupied amount is visible as the drop in the free-slot count.
- R3: The token offered on the reserve port is the tail index. The tail advances only on an accepted request, by the normalized amount, modulo DEPTH.
- R4: The free-slot count drops by the normalized amount of an accepted request and rises by the slot amounts of all entries retired in that cycle. Both changes apply together and the count never exceeds DEPTH.
- R5: `rsv_ready` is high exactly when the free-slot count is at least the normalized amount of the presented request. With zero free slots it is low even for a zero micro-op request.
- R6: Only the head entry, and only once it is marked executed, may retire. The head then advances by that entry's slot amount modulo DEPTH, so a later entry marked first waits for it.
- R7: In one cycle at most MAX_RETIRE consecutive executed entries retire (0 means no limit). They are reported on lanes 0 upward in program order, with valid lanes contiguous from lane 0.
- R8: An executed notification must name an occupied entry that is not yet marked executed. Any other notification is a usage error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rsv_valid | input | 1 | Reservation request |
| rsv_uops | input | UOP_W | Micro-op count of the request |
| rsv_ready | output | 1 | Enough free slots for the request |
| rsv_token | output | IDX_W | Token (first slot index) given to the request |
| exe_valid | input | 1 | Executed notification |
| exe_token | input | IDX_W | Token of the executed entry |
| ret_valid | output | LANES | Per-lane retire valid, lane 0 oldest |
| ret_token | output | LANES x IDX_W | Per-lane retired token |
| avail | output | CNT_W | Free-slot count |

## Verification
Reservation and retirement can fall in the same cycle, and both change the free-slot count. The bench marks the head entry executed, so that it is retiring in the next cycle, and presents a three-slot request in that same cycle. It then requires the count to land at the old value minus three plus the retired entry's two slots. Executed marks given out of order check that a younger entry waits for the head. Marks given in reverse order across three entries check the per-cycle lane limit.

// File: rtl/rq_pkg.sv
// Shared helpers for the retire queue.
// Assumes: pointer and increment are each below the queue depth.
package rq_pkg;
    // Circular add of an increment to a slot pointer.
    function automatic int unsigned wrap_add(int unsigned ptr, int unsigned inc, int unsigned depth);
        int unsigned s;
        s = ptr + inc;
        return (s >= depth) ? s - depth : s;
    endfunction
endpackage

// File: rtl/rq_normalize.sv
// Turns a raw micro-op count into the slot amount an entry occupies.
// Assumes: DEPTH fits in CNT_W bits.
module rq_normalize #(
    parameter int DEPTH = 16,
    parameter int UOP_W = 5,
    parameter int CNT_W = 5
) (
    input  logic [UOP_W-1:0] uops,
    output logic [CNT_W-1:0] slots
);
    // Clamp to the range 1..DEPTH.
    always_comb begin
        if (uops == '0)
            slots = CNT_W'(1);
        else if (32'(uops) > DEPTH)
            slots = CNT_W'(DEPTH);
        else
            slots = CNT_W'(uops);
    end
endmodule

// File: rtl/rq_entries.sv
// Per-slot state: occupied, executed and slot amount, held at the token index.
// Assumes: a write and a clear never target the same index in one cycle.
module rq_entries #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [CNT_W-1:0]            wr_cnt,
    input  logic                        exe_en,
    input  logic [IDX_W-1:0]            exe_idx,
    input  logic [DEPTH-1:0]            clr,
    output logic [DEPTH-1:0]            valid_q,
    output logic [DEPTH-1:0]            exec_q,
    output logic [DEPTH-1:0][CNT_W-1:0] cnt_q
);
    // Allocate, mark executed and release entries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            exec_q  <= '0;
            cnt_q   <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (clr[i]) begin
                    valid_q[i] <= 1'b0;
                    exec_q[i]  <= 1'b0;
                end
                if (wr_en && 32'(wr_idx) == i) begin
                    valid_q[i] <= 1'b1;
                    exec_q[i]  <= 1'b0;
                    cnt_q[i]   <= wr_cnt;
                end
                if (exe_en && 32'(exe_idx) == i && valid_q[i])
                    exec_q[i] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rq_retire_select.sv
// Walks from the head over consecutive executed entries, up to LANES of them.
// Assumes: occupied equals the sum of slot amounts of live entries.
module rq_retire_select #(
    parameter int DEPTH = 16,
    parameter int LANES = 2,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5
) (
    input  logic [IDX_W-1:0]            head,
    input  logic [CNT_W-1:0]            occupied,
    input  logic [DEPTH-1:0]            valid,
    input  logic [DEPTH-1:0]            exec,
    input  logic [DEPTH-1:0][CNT_W-1:0] cnt,
    output logic [LANES-1:0]            lane_valid,
    output logic [LANES-1:0][IDX_W-1:0] lane_tok,
    output logic [DEPTH-1:0]            clr,
    output logic [CNT_W-1:0]            freed,
    output logic [IDX_W-1:0]            next_head
);
    import rq_pkg::*;

    // Chain the lanes: each lane starts where the previous retired entry ended.
    always_comb begin
        logic [IDX_W-1:0] ptr;
        logic [CNT_W-1:0] used;
        logic             go;
        ptr  = head;
        used = '0;
        go   = 1'b1;
        clr  = '0;
        for (int i = 0; i < LANES; i++) begin
            go = go && (used < occupied) && valid[ptr] && exec[ptr];
            lane_valid[i] = go;
            lane_tok[i]   = ptr;
            if (go) begin
                clr[ptr] = 1'b1;
                used     = used + cnt[ptr];
                ptr      = IDX_W'(wrap_add(32'(ptr), 32'(cnt[ptr]), DEPTH));
            end
        end
        freed     = used;
        next_head = ptr;
    end
endmodule

// File: rtl/retire_queue.sv
// Variable-slot circular retire queue: reserve, mark executed, retire in order.
// Assumes: notifications only name live, not-yet-executed tokens.
module retire_queue #(
    parameter int DEPTH      = 16,
    parameter int UOP_W      = 5,
    parameter int MAX_RETIRE = 2,
    localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W     = $clog2(DEPTH + 1),
    localparam int LANES     = (MAX_RETIRE == 0) ? DEPTH : MAX_RETIRE
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rsv_valid,
    input  logic [UOP_W-1:0]            rsv_uops,
    output logic                        rsv_ready,
    output logic [IDX_W-1:0]            rsv_token,
    input  logic                        exe_valid,
    input  logic [IDX_W-1:0]            exe_token,
    output logic [LANES-1:0]            ret_valid,
    output logic [LANES-1:0][IDX_W-1:0] ret_token,
    output logic [CNT_W-1:0]            avail
);
    import rq_pkg::*;

    logic [IDX_W-1:0]            head_q, tail_q, head_d;
    logic [CNT_W-1:0]            avail_q, slots, freed, occupied;
    logic                        accept;
    logic [DEPTH-1:0]            ent_valid, ent_exec, clr;
    logic [DEPTH-1:0][CNT_W-1:0] ent_cnt;

    rq_normalize #(.DEPTH(DEPTH), .UOP_W(UOP_W), .CNT_W(CNT_W)) u_norm (
        .uops (rsv_uops),
        .slots(slots)
    );

    rq_entries #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_ent (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (accept),
        .wr_idx (tail_q),
        .wr_cnt (slots),
        .exe_en (exe_valid),
        .exe_idx(exe_token),
        .clr    (clr),
        .valid_q(ent_valid),
        .exec_q (ent_exec),
        .cnt_q  (ent_cnt)
    );

    rq_retire_select #(.DEPTH(DEPTH), .LANES(LANES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_sel (
        .head      (head_q),
        .occupied  (occupied),
        .valid     (ent_valid),
        .exec      (ent_exec),
        .cnt       (ent_cnt),
        .lane_valid(ret_valid),
        .lane_tok  (ret_token),
        .clr       (clr),
        .freed     (freed),
        .next_head (head_d)
    );

    // Admission decision against the free-slot count.
    always_comb begin
        occupied  = CNT_W'(DEPTH) - avail_q;
        rsv_ready = (avail_q >= slots);
        accept    = rsv_valid && rsv_ready;
        rsv_token = tail_q;
        avail     = avail_q;
    end

    // Pointer and free-count update, combining reserve and retire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            avail_q <= CNT_W'(DEPTH);
        end else begin
            head_q  <= head_d;
            if (accept)
                tail_q <= IDX_W'(wrap_add(32'(tail_q), 32'(slots), DEPTH));
            avail_q <= avail_q - (accept ? slots : '0) + freed;
        end
    end
endmodule

// File: rtl/retire_queue_checker.sv
// Protocol and state checks for retire_queue, attached by bind.
// Assumes: the internal entry flags are exposed through the bind connections.
module retire_queue_checker #(
    parameter int DEPTH = 16,
    parameter int IDX_W = 4,
    parameter int CNT_W = 5,
    parameter int LANES = 2
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rsv_valid,
    input logic                        rsv_ready,
    input logic [IDX_W-1:0]            rsv_token,
    input logic                        exe_valid,
    input logic [IDX_W-1:0]            exe_token,
    input logic [LANES-1:0]            ret_valid,
    input logic [LANES-1:0][IDX_W-1:0] ret_token,
    input logic [CNT_W-1:0]            avail,
    input logic [DEPTH-1:0]            ent_valid,
    input logic [DEPTH-1:0]            ent_exec
);
    AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsv_valid && rsv_ready) |=> rsv_token == $past(rsv_token)); // R3
    AST_AVAIL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(avail) <= DEPTH); // R4
    AST_NO_RISE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid == '0 |=> avail <= $past(avail)); // R4
    AST_FULL_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        avail == '0 |-> !rsv_ready); // R5
    AST_HEAD_EXECUTED: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid[0] |-> (ent_valid[ret_token[0]] && ent_exec[ret_token[0]] && 32'(avail) < DEPTH)); // R6
    AST_LANES_CONTIG: assert property (@(posedge clk) disable iff (!rst_n)
        ((ret_valid + 1'b1) & ret_valid) == '0); // R7
    AST_EXE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        exe_valid |-> (ent_valid[exe_token] && !ent_exec[exe_token])); // R8
endmodule

bind retire_queue retire_queue_checker #(
    .DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W), .LANES(LANES)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rsv_valid(rsv_valid),
    .rsv_ready(rsv_ready),
    .rsv_token(rsv_token),
    .exe_valid(exe_valid),
    .exe_token(exe_token),
    .ret_valid(ret_valid),
    .ret_token(ret_token),
    .avail    (avail),
    .ent_valid(ent_valid),
    .ent_exec (ent_exec)
);

// File: tb/retire_queue_bench.sv
module retire_queue_bench;
    localparam int DEPTH = 16;
    localparam int UOP_W = 5;
    localparam int MAXR  = 2;
    localparam int IDX_W = 4;
    localparam int CNT_W = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rsv_valid = 1'b0;
    logic [UOP_W-1:0] rsv_uops = '0;
    logic rsv_ready;
    logic [IDX_W-1:0] rsv_token;
    logic exe_valid = 1'b0;
    logic [IDX_W-1:0] exe_token = '0;
    logic [MAXR-1:0] ret_valid;
    logic [MAXR-1:0][IDX_W-1:0] ret_token;
    logic [CNT_W-1:0] avail;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    retire_queue #(.DEPTH(DEPTH), .UOP_W(UOP_W), .MAX_RETIRE(MAXR)) u_retire_queue (
        .clk(clk), .rst_n(rst_n),
        .rsv_valid(rsv_valid), .rsv_uops(rsv_uops), .rsv_ready(rsv_ready), .rsv_token(rsv_token),
        .exe_valid(exe_valid), .exe_token(exe_token),
        .ret_valid(ret_valid), .ret_token(ret_token), .avail(avail)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic reserve(input int uops, input int exp_tok, input string req);
        rsv_valid = 1'b1;
        rsv_uops  = UOP_W'(uops);
        #1;
        check(rsv_token == IDX_W'(exp_tok), req, rsv_token, exp_tok);
        check(rsv_ready == 1'b1, req, rsv_ready, 1);
        tick();
        rsv_valid = 1'b0;
    endtask

    task automatic mark(input int tok);
        exe_valid = 1'b1;
        exe_token = IDX_W'(tok);
        tick();
        exe_valid = 1'b0;
    endtask

    task automatic t_reset;
        check(avail == CNT_W'(DEPTH), "R1", avail, DEPTH);
        check(rsv_token == 0, "R1", rsv_token, 0);
        check(ret_valid == 0, "R1", ret_valid, 0);
        check(rsv_ready == 1'b1, "R1", rsv_ready, 1);
    endtask

    task automatic t_basic;
        reserve(3, 0, "R3");
        check(avail == 13, "R2", avail, 13);
        reserve(0, 3, "R3");
        check(avail == 12, "R2", avail, 12);
        check(rsv_token == 4, "R3", rsv_token, 4);
        rsv_uops = 13; #1;
        check(rsv_ready == 1'b0, "R5", rsv_ready, 0);
        rsv_uops = 12; #1;
        check(rsv_ready == 1'b1, "R5", rsv_ready, 1);
        mark(3);
        check(ret_valid == 0, "R6", ret_valid, 0);
        mark(0);
        check(ret_valid == 2'b11, "R6", ret_valid, 3);
        check(ret_token[0] == 0 && ret_token[1] == 3, "R6", ret_token[1], 3);
        tick();
        check(avail == 16, "R4", avail, 16);
        check(ret_valid == 0, "R6", ret_valid, 0);
    endtask

    task automatic t_clamp;
        rsv_uops = 31; #1;
        check(rsv_ready == 1'b1, "R5", rsv_ready, 1);
        reserve(31, 4, "R3");
        check(avail == 0, "R2", avail, 0);
        rsv_uops = 0; #1;
        check(rsv_ready == 1'b0, "R5", rsv_ready, 0);
        check(rsv_token == 4, "R3", rsv_token, 4);
        mark(4);
        check(ret_valid == 2'b01 && ret_token[0] == 4, "R6", ret_valid, 1);
        tick();
        check(avail == 16, "R4", avail, 16);
    endtask

    task automatic t_limit;
        reserve(1, 4, "R3");
        reserve(1, 5, "R3");
        reserve(1, 6, "R3");
        mark(6);
        mark(5);
        check(ret_valid == 0, "R6", ret_valid, 0);
        mark(4);
        check(ret_valid == 2'b11, "R7", ret_valid, 3);
        check(ret_token[0] == 4 && ret_token[1] == 5, "R7", ret_token[0], 4);
        check(avail == 13, "R7", avail, 13);
        tick();
        check(avail == 15, "R7", avail, 15);
        check(ret_valid == 2'b01 && ret_token[0] == 6, "R7", ret_token[0], 6);
        tick();
        check(avail == 16, "R7", avail, 16);
    endtask

    task automatic t_same_cycle;
        reserve(2, 7, "R3");
        check(avail == 14, "R4", avail, 14);
        mark(7);
        check(ret_valid == 2'b01, "R4", ret_valid, 1);
        reserve(3, 9, "R3");
        check(avail == 13, "R4", avail, 13);
        check(ret_valid == 0, "R4", ret_valid, 0);
    endtask

    task automatic t_wrap;
        reserve(6, 12, "R3");
        reserve(0, 2, "R3");
        check(avail == 6, "R2", avail, 6);
        mark(9);
        mark(12);
        mark(2);
        check(ret_valid == 2'b01 && ret_token[0] == 2, "R6", ret_token[0], 2);
        tick();
        check(avail == 16, "R4", avail, 16);
        check(ret_valid == 0 && rsv_token == 3, "R3", rsv_token, 3);
    endtask

    initial begin
        fork
            begin
                repeat (4) tick();
                rst_n = 1'b1;
                tick();
                t_reset();
                t_basic();
                t_clamp();
                t_limit();
                t_same_cycle();
                t_wrap();
            end
            begin
                repeat (5000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule